// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block sits between a synchronous host port and a 4-bit-wide asynchronous DRAM. It turns each host request into a sequence of row strobe, column strobe, write-enable and output-enable transitions. The 9-bit address pins are shared: the row half of the 18-bit host address goes out first, and the column half follows. Every timing limit is a parameter in nanoseconds. The controller converts each limit to a whole number of clock cycles by rounding up, so the same code works at any clock period.

After an access the row stays open. A later request to the same row becomes a short page cycle, in which only the column strobe toggles. A request to a different row closes the open row, waits out the precharge time and opens the new row. The controller also tracks how long the row strobe has been low. It closes the row before the maximum allowed low time, even when requests keep hitting the row or the host goes quiet.

An external refresher asks for the DRAM bus on a request line. The controller first closes any open row and lets the precharge time pass. It then raises a grant and keeps all of its strobes inactive until the request is dropped.

Top module: `fpdram_ctrl`

## Requirements
- R1: After reset, all four DRAM strobes are high (inactive), `ready` is 1, and `rvalid`, `ref_gnt` and `dram_dq_oe` are 0.
- R2: The row is `req_addr[17:9]`, present on `dram_addr` when `dram_ras_n` falls. The column is `req_addr[8:0]`, present when `dram_cas_n` falls.
- R3: `dram_ras_n` stays high for at least ceil(T_RP_NS/CLK_NS) cycles before each fall, which is 10 cycles at a 4 ns clock.
- R4: `dram_cas_n` falls only while `dram_ras_n` is low. On a row's first access, it falls at least ceil(T_RCD_NS/CLK_NS) cycles after `dram_ras_n` falls (5 cycles). The row address is held at least ceil(T_RAH_NS/CLK_NS) cycles after `dram_ras_n` falls (2 cycles).
- R5: Each `dram_cas_n` low pulse lasts at least 4 cycles. Between page accesses, `dram_cas_n` stays high at least 3 cycles, and successive falls inside one row are at least 9 cycles apart.
- R6: A request whose row equals the open row is served without `dram_ras_n` rising.
- R7: A request to a different row raises `dram_ras_n`, waits the precharge time, and opens the new row with a fresh `dram_ras_n` fall.
- R8: `dram_ras_n` never stays low for more than ceil(T_RASP_NS/CLK_NS) cycles. This holds both under a continuous stream of same-row requests and while the host is idle.
- R9: On a write, `dram_we_n` is low and `dram_dq_oe` is 1 before `dram_cas_n` falls, and `dram_oe_n` stays high. On a read, `dram_dq_oe` stays 0.
- R10: A read gives one `rvalid` pulse, one cycle long, with the data stored at that address. The column is on the pins for at least 7 cycles, and `dram_cas_n` is low for at least 6 cycles, before the sample is taken.
- R11: `ready` goes low in the cycle after a request is accepted (`req` and `ready` both 1 at a clock edge). It stays low until the `rvalid` cycle of a read, or until `dram_cas_n` returns high on a write.
- R12: While `ref_req` is 1, `ready` is 0. `ref_gnt` rises only after `dram_ras_n` has been high for the precharge time. While `ref_gnt` is 1, all strobes stay high. `ref_gnt` drops one cycle after `ref_req` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Host request, taken when `ready` is 1 |
| req_we | input | 1 | 1 for write, 0 for read |
| req_addr | input | 18 | Word address: row in the upper 9 bits, column in the lower 9 |
| req_wdata | input | 4 | Write data |
| ready | output | 1 | Controller can accept a request |
| rvalid | output | 1 | One-cycle pulse marking `rdata` valid |
| rdata | output | 4 | Read data |
| ref_req | input | 1 | External refresher asks for the DRAM bus |
| ref_gnt | output | 1 | DRAM bus handed to the refresher |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 9 | Multiplexed row/column address |
| dram_dq_oe | output | 1 | Drive enable for the data pins |
| dram_dq_out | output | 4 | Data driven to the DRAM |
| dram_dq_in | input | 4 | Data returned by the DRAM |

## Verification
The hardest case to reach from the ports is the forced close of a row that is still being hit. A single request never comes near the row-strobe limit. The bench therefore lowers that limit to 400 ns and sends an unbroken stream of same-row reads, each one accepted in the first precharge cycle of the one before. This pushes the open-row time past the limit, and the bench then counts the new row activations that appear although no request missed. A quiet period after the stream shows that a row left open with no traffic is also closed.

// File: rtl/fpdram_ctrl.sv
`timescale 1ns/1ps
module fpdram_ctrl #(
  parameter int CLK_NS    = 4,
  parameter int ROW_W     = 9,
  parameter int DQ_W      = 4,
  parameter int T_RP_NS   = 40,
  parameter int T_RAS_NS  = 50,
  parameter int T_RASP_NS = 100000,
  parameter int T_RCD_NS  = 18,
  parameter int T_RAH_NS  = 8,
  parameter int T_CAS_NS  = 14,
  parameter int T_CP_NS   = 10,
  parameter int T_PC_NS   = 36,
  parameter int T_AA_NS   = 26,
  parameter int T_CAC_NS  = 14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req,
  input  logic                 req_we,
  input  logic [2*ROW_W-1:0]   req_addr,
  input  logic [DQ_W-1:0]      req_wdata,
  output logic                 ready,
  output logic                 rvalid,
  output logic [DQ_W-1:0]      rdata,
  input  logic                 ref_req,
  output logic                 ref_gnt,
  output logic                 dram_ras_n,
  output logic                 dram_cas_n,
  output logic                 dram_we_n,
  output logic                 dram_oe_n,
  output logic [ROW_W-1:0]     dram_addr,
  output logic                 dram_dq_oe,
  output logic [DQ_W-1:0]      dram_dq_out,
  input  logic [DQ_W-1:0]      dram_dq_in
);

  function automatic int to_cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int AW       = 2 * ROW_W;
  localparam int RP_C     = to_cyc(T_RP_NS);
  localparam int RASMIN_C = to_cyc(T_RAS_NS);
  localparam int RASP_C   = to_cyc(T_RASP_NS);
  localparam int RCD_C    = to_cyc(T_RCD_NS);
  localparam int RAH_C    = to_cyc(T_RAH_NS);
  localparam int CAS_C    = to_cyc(T_CAS_NS);
  localparam int CP_C     = to_cyc(T_CP_NS);
  localparam int PC_C     = to_cyc(T_PC_NS);
  localparam int AA_C     = to_cyc(T_AA_NS);
  localparam int CAC_C    = to_cyc(T_CAC_NS);
  localparam int RCD_REM  = (RCD_C > RAH_C) ? RCD_C - RAH_C : 1;
  localparam int WR_LEN   = (CAS_C > PC_C - CP_C - 1) ? CAS_C : PC_C - CP_C - 1;
  localparam int RD_TMP   = (WR_LEN > CAC_C) ? WR_LEN : CAC_C;
  localparam int RD_LEN   = (RD_TMP > AA_C - 1) ? RD_TMP : AA_C - 1;
  localparam int HIT_LIM  = RASP_C - RD_LEN - CP_C - 3;
  localparam int CNT_W    = $clog2(RD_LEN + RCD_REM + RAH_C + CP_C + 2) + 1;
  localparam int RAS_W    = $clog2(RASP_C + 2) + 1;
  localparam int HI_W     = $clog2(RP_C + 1) + 1;

  typedef enum logic [2:0] {
    S_IDLE, S_RAH, S_RCD, S_COL, S_CAS, S_CP, S_OPEN, S_GNT
  } st_t;

  st_t              state, nstate;
  logic [CNT_W-1:0] cnt, ncnt;
  logic [RAS_W-1:0] ras_cnt;
  logic [HI_W-1:0]  hi_cnt;
  logic             pend, p_we, c_we;
  logic [AW-1:0]    p_addr, c_addr;
  logic [DQ_W-1:0]  p_wdata, c_wdata;
  logic             take_row, take_col;

  wire ras_low  = (state != S_IDLE) && (state != S_GNT);
  wire pre_ok   = hi_cnt >= HI_W'(RP_C - 1);
  wire too_long = ras_cnt >= RAS_W'(HIT_LIM);
  wire min_ok   = ras_cnt >= RAS_W'(RASMIN_C - 1);
  wire row_hit  = p_addr[AW-1:ROW_W] == c_addr[AW-1:ROW_W];
  wire cas_end  = (state == S_CAS) && (cnt == '0);
  wire accept   = req && ready;

  assign ready = !pend && !ref_req &&
                 (state == S_IDLE || state == S_OPEN || state == S_CP);
  assign ref_gnt     = state == S_GNT;
  assign dram_ras_n  = !ras_low;
  assign dram_cas_n  = state != S_CAS;
  assign dram_dq_oe  = c_we && (state == S_RCD || state == S_COL || state == S_CAS);
  assign dram_we_n   = !dram_dq_oe;
  assign dram_oe_n   = !(!c_we && state == S_CAS);
  assign dram_dq_out = c_wdata;
  assign dram_addr   = (state == S_IDLE) ? p_addr[AW-1:ROW_W] :
                       (state == S_RAH)  ? c_addr[AW-1:ROW_W] : c_addr[ROW_W-1:0];

  always_comb begin
    nstate   = state;
    ncnt     = (cnt != '0) ? cnt - 1'b1 : '0;
    take_row = 1'b0;
    take_col = 1'b0;
    case (state)
      S_IDLE: begin
        if (pend && pre_ok) begin
          nstate   = S_RAH;
          ncnt     = CNT_W'(RAH_C - 1);
          take_row = 1'b1;
        end else if (!pend && ref_req && pre_ok) begin
          nstate = S_GNT;
        end
      end
      S_RAH: if (cnt == '0) begin
        nstate = S_RCD;
        ncnt   = CNT_W'(RCD_REM - 1);
      end
      S_RCD, S_COL: if (cnt == '0) begin
        nstate = S_CAS;
        ncnt   = c_we ? CNT_W'(WR_LEN - 1) : CNT_W'(RD_LEN - 1);
      end
      S_CAS: if (cnt == '0) begin
        nstate = S_CP;
        ncnt   = CNT_W'(CP_C - 1);
      end
      S_GNT: if (!ref_req) nstate = S_IDLE;
      default: ;
    endcase
    if (state == S_OPEN || (state == S_CP && cnt == '0)) begin
      if (too_long) begin
        nstate = S_IDLE;
      end else if (pend && row_hit) begin
        nstate   = S_COL;
        ncnt     = '0;
        take_col = 1'b1;
      end else if ((pend || ref_req) && min_ok) begin
        nstate = S_IDLE;
      end else begin
        nstate = S_OPEN;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      ras_cnt <= '0;
      hi_cnt  <= '0;
      pend    <= 1'b0;
      p_we    <= 1'b0;
      p_addr  <= '0;
      p_wdata <= '0;
      c_we    <= 1'b0;
      c_addr  <= '0;
      c_wdata <= '0;
      rvalid  <= 1'b0;
      rdata   <= '0;
    end else begin
      state <= nstate;
      cnt   <= ncnt;
      if (!ras_low) ras_cnt <= '0;
      else if (ras_cnt != '1) ras_cnt <= ras_cnt + 1'b1;
      if (state != S_IDLE) hi_cnt <= '0;
      else if (hi_cnt != HI_W'(RP_C)) hi_cnt <= hi_cnt + 1'b1;
      if (accept) begin
        pend    <= 1'b1;
        p_we    <= req_we;
        p_addr  <= req_addr;
        p_wdata <= req_wdata;
      end else if (take_row || take_col) begin
        pend    <= 1'b0;
        c_we    <= p_we;
        c_addr  <= p_addr;
        c_wdata <= p_wdata;
      end
      rvalid <= cas_end && !c_we;
      if (cas_end && !c_we) rdata <= dram_dq_in;
    end
  end

  // R8
  ras_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_ras_n |-> ras_cnt < RAS_W'(RASP_C));

  // R3
  precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> $past(hi_cnt) >= HI_W'(RP_C - 1));

  // R4
  cas_inside_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_cas_n |-> !dram_ras_n);

  // R9
  early_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_cas_n) && !dram_we_n) |-> ($past(!dram_we_n) && dram_oe_n));

  // R12
  grant_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_gnt |-> (dram_ras_n && dram_cas_n && dram_we_n && !ready));

  // R10
  rvalid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |=> !rvalid);

endmodule

// File: tb/fpdram_ctrl_test.sv
`timescale 1ns/1ps
module fpdram_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        req = 1'b0, req_we = 1'b0, ref_req = 1'b0;
  logic [17:0] req_addr = '0;
  logic [3:0]  req_wdata = '0;
  logic        ready, rvalid, ref_gnt;
  logic [3:0]  rdata;
  logic        ras_n, cas_n, we_n, oe_n, dq_oe;
  logic [8:0]  addr;
  logic [3:0]  dq_out;
  logic [3:0]  dq_model = '0;

  fpdram_ctrl #(.T_RASP_NS(400)) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .ready(ready), .rvalid(rvalid), .rdata(rdata),
    .ref_req(ref_req), .ref_gnt(ref_gnt), .dram_ras_n(ras_n), .dram_cas_n(cas_n),
    .dram_we_n(we_n), .dram_oe_n(oe_n), .dram_addr(addr), .dram_dq_oe(dq_oe),
    .dram_dq_out(dq_out), .dram_dq_in(dq_model));

  int checks = 0, fails = 0;
  bit done = 0;
  logic [3:0] dram_mem [logic [17:0]];
  logic [3:0] shadow   [logic [17:0]];
  logic [17:0] exp_addr = '0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // port monitor and DRAM model, sampled on the falling clock edge
  int ras_hi = 0, ras_lo = 0, cas_lo = 0, cas_hi = 0, since_fall = 0, addr_st = 0;
  int ras_falls = 0, page_hits = 0;
  bit first_cas = 0, row_pend = 0, cur_read = 0;
  logic p_ras = 1, p_cas = 1, p_we = 1, p_gnt = 0;
  logic [8:0] p_addr = '0, row_l = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!ras_n && p_ras) begin
        chk(ras_hi >= 10, "R3 precharge before row open", ras_hi, 10);
        row_l = addr; ras_falls++; first_cas = 1; row_pend = 1;
      end else if (!ras_n && row_pend && addr != p_addr) begin
        chk(ras_lo >= 2, "R4 row address hold", ras_lo, 2);
        row_pend = 0;
      end
      if (ras_n && !p_ras) chk(ras_lo <= 100, "R8 row strobe low time", ras_lo, 100);
      if (!cas_n && p_cas) begin
        chk(!ras_n, "R4 column strobe inside row strobe", ras_n, 0);
        if (first_cas) chk(ras_lo >= 5, "R4 row to column delay", ras_lo, 5);
        else begin
          chk(cas_hi >= 3, "R5 column precharge", cas_hi, 3);
          chk(since_fall >= 9, "R5 page cycle", since_fall, 9);
          page_hits++;
        end
        first_cas = 0; since_fall = 0;
        chk({row_l, addr} == exp_addr, "R2 address split", int'({row_l, addr}), int'(exp_addr));
        cur_read = we_n;
        if (!we_n) begin
          chk(!p_we && dq_oe && oe_n, "R9 early write", int'({p_we, dq_oe, oe_n}), 3);
          dram_mem[{row_l, addr}] = dq_out;
        end else begin
          chk(!dq_oe, "R9 no drive on read", dq_oe, 0);
          dq_model = dram_mem.exists({row_l, addr}) ? dram_mem[{row_l, addr}] : 4'h0;
        end
      end
      if (cas_n && !p_cas) begin
        chk(cas_lo >= (cur_read ? 6 : 4), "R5 column pulse width", cas_lo, cur_read ? 6 : 4);
        if (cur_read) chk(addr_st >= 7, "R10 column access time", addr_st, 7);
      end
      if (ref_gnt && !p_gnt)
        chk(ras_n && cas_n && ras_hi >= 10, "R12 grant after precharge", ras_hi, 10);
    end
    ras_hi = ras_n ? ras_hi + 1 : 0;
    ras_lo = ras_n ? 0 : ras_lo + 1;
    cas_hi = cas_n ? cas_hi + 1 : 0;
    cas_lo = cas_n ? 0 : cas_lo + 1;
    since_fall++;
    addr_st = (addr == p_addr) ? addr_st + 1 : 1;
    p_ras = ras_n; p_cas = cas_n; p_we = we_n; p_gnt = ref_gnt; p_addr = addr;
  end

  task automatic issue(input logic we, input logic [17:0] a, input logic [3:0] d);
    while (!ready) @(negedge clk);
    req = 1; req_we = we; req_addr = a; req_wdata = d; exp_addr = a;
    @(negedge clk);
    req = 0;
    chk(!ready, "R11 ready drops after accept", ready, 0);
  endtask

  task automatic do_write(input logic [17:0] a, input logic [3:0] d);
    bit okr;
    int n;
    okr = 1; n = 0;
    issue(1, a, d);
    shadow[a] = d;
    while (cas_n && n < 300) begin if (ready) okr = 0; @(negedge clk); n++; end
    while (!cas_n && n < 300) begin if (ready) okr = 0; @(negedge clk); n++; end
    chk(okr && ready, "R11 ready returns when write strobe ends", ready, 1);
  endtask

  task automatic do_read(input logic [17:0] a);
    logic [3:0] e;
    bit okr;
    int n;
    e = shadow.exists(a) ? shadow[a] : 4'h0;
    okr = 1; n = 0;
    issue(0, a, 4'h0);
    while (!rvalid && n < 300) begin if (ready) okr = 0; @(negedge clk); n++; end
    chk(rvalid, "R10 read completes", rvalid, 1);
    chk(rdata == e, "R10 read data", rdata, e);
    chk(okr && ready, "R11 ready returns with rvalid", ready, 1);
    @(negedge clk);
    chk(!rvalid, "R10 rvalid is one cycle", rvalid, 0);
  endtask

  task automatic t_reset();
    chk(ras_n && cas_n && we_n && oe_n, "R1 strobes idle", int'({ras_n, cas_n, we_n, oe_n}), 15);
    chk(ready && !rvalid && !ref_gnt && !dq_oe, "R1 host side idle",
        int'({ready, rvalid, ref_gnt, dq_oe}), 8);
  endtask

  task automatic t_basic();
    do_write(18'h2A5C3, 4'hB);
    chk(row_l == 9'h152, "R2 row half on pins", row_l, 9'h152);
    do_read(18'h2A5C3);
    do_read(18'h00011);
  endtask

  task automatic t_page();
    int f0, h0;
    do_write({9'd5, 9'd1}, 4'h1);
    f0 = ras_falls; h0 = page_hits;
    do_write({9'd5, 9'd2}, 4'h2);
    do_write({9'd5, 9'd3}, 4'h3);
    do_read({9'd5, 9'd1});
    do_read({9'd5, 9'd3});
    chk(ras_falls == f0, "R6 same row keeps row open", ras_falls, f0);
    chk(page_hits - h0 == 4, "R6 page cycles used", page_hits - h0, 4);
  endtask

  task automatic t_miss();
    int f0;
    do_write({9'd10, 9'd4}, 4'h6);
    f0 = ras_falls;
    do_write({9'd11, 9'd4}, 4'h9);
    chk(ras_falls == f0 + 1, "R7 new row reopened", ras_falls, f0 + 1);
    do_read({9'd10, 9'd4});
    chk(ras_falls == f0 + 2, "R7 back to first row", ras_falls, f0 + 2);
  endtask

  task automatic t_long_row();
    int f0;
    do_write({9'd3, 9'd0}, 4'hC);
    f0 = ras_falls;
    for (int i = 0; i < 14; i++) do_read({9'd3, 9'(i % 4)});
    chk(ras_falls > f0, "R8 row closed under continuous hits", ras_falls - f0, 1);
    repeat (110) @(negedge clk);
    chk(ras_n, "R8 idle row closed", ras_n, 1);
  endtask

  task automatic t_refresh();
    int n;
    bit quiet;
    do_write({9'd20, 9'd0}, 4'h7);
    ref_req = 1;
    @(negedge clk);
    chk(!ready, "R12 ready low during refresh request", ready, 0);
    n = 0;
    while (!ref_gnt && n < 100) begin @(negedge clk); n++; end
    chk(ref_gnt, "R12 grant given", ref_gnt, 1);
    quiet = 1;
    repeat (6) begin
      if (!(ras_n && cas_n && we_n && oe_n && !ready)) quiet = 0;
      @(negedge clk);
    end
    chk(quiet, "R12 strobes idle while granted", quiet, 1);
    ref_req = 0;
    @(negedge clk);
    chk(!ref_gnt, "R12 grant released", ref_gnt, 0);
    do_read({9'd20, 9'd0});
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_page();
    t_miss();
    t_long_row();
    t_refresh();
    repeat (5) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule